// File: doc/BRIEF.md
# Burst Address Sequencer

This block generates the address for short bursts of up to four beats. A memory controller hands it a full address once, on a load cycle. On each following advance cycle the block steps the two lowest address bits to the next beat. The upper bits keep the value that was loaded. A static strap input picks the stepping order. The order is either a wrapping add-one sequence or an exclusive-OR interleave of the start bits with a beat count.

A stall input freezes the whole state, so the cycle before the stall is stretched. Advancing does not depend on any chip select or access type, so a burst keeps stepping on every enabled advance cycle. It wraps indefinitely past the fourth beat. The outputs are the current address and a two-bit beat index. Both come directly from registers and the strap, so a new address appears one clock edge after the cycle that requested it.

Top module: `burst_addr_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the following cycle shows `addr_out` = 0 and `beat` = 0.
- R2: An enabled edge (`hold` = 0) with `adv` = 0 loads the block: afterwards `addr_out` equals the `addr_in` sampled at that edge and `beat` = 0.
- R3: An enabled edge with `adv` = 1 increments `beat` by one modulo 4.
- R4: With `interleave` = 0, the low bits `addr_out[1:0]` equal (loaded low bits + `beat`) modulo 4. From start 01 this gives 01, 10, 11, 00.
- R5: With `interleave` = 1, the low bits `addr_out[1:0]` equal the loaded low bits XOR `beat`. From start 01 this gives 01, 00, 11, 10.
- R6: An advance never changes `addr_out[ADDR_W-1:2]`; those bits keep the loaded value.
- R7: An edge with `hold` = 1 changes neither `addr_out` nor `beat`, whatever `adv` and `addr_in` carry.
- R8: Advancing past the fourth beat keeps wrapping. After four advances, `addr_out` equals the loaded address again and `beat` = 0, with no error indication.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| hold | input | 1 | Stall: 1 freezes all state at this edge |
| adv | input | 1 | 1 = advance the burst, 0 = load `addr_in` |
| interleave | input | 1 | Static order strap: 0 linear, 1 interleaved |
| addr_in | input | ADDR_W | External address captured on a load |
| addr_out | output | ADDR_W | Current burst address |
| beat | output | 2 | Beats advanced since the last load, modulo 4 |

## Verification
Directed bursts start from low bits 01 in both orders and are compared with the expected beat-by-beat sequences. Stepping through them separates add-one wrapping from XOR interleaving, because the two orders differ on beats 1 and 3. Runs longer than four beats show that the wrap returns to the loaded address. Stalls carry conflicting `adv` and `addr_in` values, so any leak of a stalled load or advance shows up. A long random mix of loads, advances, stalls and strap values, with random upper bits, then checks that the upper bits survive advances and that each order holds from every start value.

// File: rtl/burst_pkg.sv
package burst_pkg;

    localparam int BEAT_W = 2;

    typedef logic [BEAT_W-1:0] beat_t;

    typedef enum logic {
        ORD_LINEAR     = 1'b0,
        ORD_INTERLEAVE = 1'b1
    } order_e;

    typedef struct packed {
        beat_t start;
        beat_t count;
    } burst_ctr_t;

    function automatic beat_t linear_low(beat_t start, beat_t count);
        return beat_t'(start + count);
    endfunction

endpackage

// File: rtl/burst_ctr_reg.sv
module burst_ctr_reg
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17,
    localparam int UPPER_W = ADDR_W - BEAT_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               hold,
    input  logic               adv,
    input  logic [ADDR_W-1:0]  addr_in,
    output logic [UPPER_W-1:0] upper_q,
    output burst_ctr_t         ctr_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            upper_q     <= '0;
            ctr_q.start <= '0;
            ctr_q.count <= '0;
        end else if (!hold) begin
            if (!adv) begin
                upper_q     <= addr_in[ADDR_W-1:BEAT_W];
                ctr_q.start <= addr_in[BEAT_W-1:0];
                ctr_q.count <= '0;
            end else begin
                ctr_q.count <= beat_t'(ctr_q.count + 1'b1);
            end
        end
    end

    // R7
    stall_freeze_chk: assert property (@(posedge clk) disable iff (rst)
        hold |=> ($stable(upper_q) && $stable(ctr_q)));

    // R6
    upper_keep_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv) |=> $stable(upper_q));

endmodule

// File: rtl/burst_order_map.sv
module burst_order_map
    import burst_pkg::*;
(
    input  burst_ctr_t ctr,
    input  order_e     ord,
    output beat_t      low
);

    beat_t lin_low;
    beat_t xor_low;

    assign lin_low = linear_low(ctr.start, ctr.count);

    for (genvar b = 0; b < BEAT_W; b++) begin : g_xor
        assign xor_low[b] = ctr.start[b] ^ ctr.count[b];
    end

    always_comb begin
        unique case (ord)
            ORD_INTERLEAVE: low = xor_low;
            default:        low = lin_low;
        endcase
    end

endmodule

// File: rtl/burst_addr_gen.sv
module burst_addr_gen
    import burst_pkg::*;
#(
    parameter int ADDR_W = 17
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hold,
    input  logic              adv,
    input  logic              interleave,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] addr_out,
    output logic [1:0]        beat
);

    localparam int UPPER_W = ADDR_W - BEAT_W;

    logic [UPPER_W-1:0] upper_q;
    burst_ctr_t         ctr_q;
    beat_t              low;
    order_e             ord;

    assign ord = order_e'(interleave);

    burst_ctr_reg #(.ADDR_W(ADDR_W)) u_reg (
        .clk     (clk),
        .rst     (rst),
        .hold    (hold),
        .adv     (adv),
        .addr_in (addr_in),
        .upper_q (upper_q),
        .ctr_q   (ctr_q)
    );

    burst_order_map u_map (
        .ctr (ctr_q),
        .ord (ord),
        .low (low)
    );

    assign addr_out = {upper_q, low};
    assign beat     = ctr_q.count;

    // R1
    reset_clear_chk: assert property (@(posedge clk)
        rst |=> (addr_out == '0 && beat == 2'd0));

    // R2
    load_capture_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && !adv) |=> (addr_out == $past(addr_in) && beat == 2'd0));

    // R3
    beat_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv) |=> (beat == 2'($past(beat) + 2'd1)));

    // R4
    linear_step_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && !interleave) |=>
            (interleave || addr_out[1:0] == 2'($past(addr_out[1:0]) + 2'd1)));

    // R5
    interleave_base_chk: assert property (@(posedge clk) disable iff (rst)
        (!hold && adv && interleave) |=>
            (!interleave || (addr_out[1:0] ^ beat) == $past(addr_out[1:0] ^ beat)));

endmodule

// File: tb/sim_burst_addr_gen.sv
module sim_burst_addr_gen;

    localparam int ADDR_W  = 17;
    localparam int UPPER_W = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              hold = 1'b0;
    logic              adv = 1'b0;
    logic              interleave = 1'b0;
    logic [ADDR_W-1:0] addr_in = '0;
    logic [ADDR_W-1:0] addr_out;
    logic [1:0]        beat;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [UPPER_W-1:0] m_upper = '0;
    logic [1:0]         m_start = '0;
    logic [1:0]         m_count = '0;

    always #5 clk = ~clk;

    burst_addr_gen #(.ADDR_W(ADDR_W)) u0 (
        .clk        (clk),
        .rst        (rst),
        .hold       (hold),
        .adv        (adv),
        .interleave (interleave),
        .addr_in    (addr_in),
        .addr_out   (addr_out),
        .beat       (beat)
    );

    function automatic logic [1:0] want_low(logic [1:0] s, logic [1:0] c, logic il);
        return il ? (s ^ c) : 2'(s + c);
    endfunction

    task automatic check(string req, logic [ADDR_W-1:0] got, logic [ADDR_W-1:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic compare_all(string req);
        check(req, addr_out, {m_upper, want_low(m_start, m_count, interleave)});
        check("R3 beat", {{UPPER_W{1'b0}}, beat}, {{UPPER_W{1'b0}}, m_count});
    endtask

    task automatic step(logic a, logic h, logic [ADDR_W-1:0] ad, logic il, string req);
        @(negedge clk);
        adv = a; hold = h; addr_in = ad; interleave = il;
        @(posedge clk);
        if (!h) begin
            if (!a) begin
                m_upper = ad[ADDR_W-1:2];
                m_start = ad[1:0];
                m_count = 2'd0;
            end else begin
                m_count = 2'(m_count + 2'd1);
            end
        end
        #1;
        compare_all(req);
    endtask

    initial begin : watchdog
        #(10 * 150000);
        if (!done) begin
            n_bad++;
            n_chk++;
            $display("FAIL watchdog: got hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin : stim
        logic [ADDR_W-1:0] a0;
        void'($urandom(32'h1b2c3d4e));
        rst = 1'b1;
        @(posedge clk);
        @(posedge clk);
        #1;
        check("R1 reset addr", addr_out, '0);
        check("R1 reset beat", {{UPPER_W{1'b0}}, beat}, '0);
        @(negedge clk);
        rst = 1'b0;

        // R4 linear sequence from 01: 01,10,11,00 then wrap (R8)
        a0 = 17'h1_2345;
        step(1'b0, 1'b0, a0, 1'b0, "R2 load");
        check("R2 load exact", addr_out, a0);
        step(1'b1, 1'b0, '0, 1'b0, "R4 linear");
        check("R4 linear beat1", {15'h0, addr_out[1:0]}, 17'h2);
        step(1'b1, 1'b0, '0, 1'b0, "R4 linear");
        check("R4 linear beat2", {15'h0, addr_out[1:0]}, 17'h3);
        step(1'b1, 1'b0, '0, 1'b0, "R4 linear");
        check("R4 linear beat3", {15'h0, addr_out[1:0]}, 17'h0);
        check("R6 upper kept", {2'b0, addr_out[ADDR_W-1:2]}, {2'b0, a0[ADDR_W-1:2]});
        step(1'b1, 1'b0, '0, 1'b0, "R8 wrap");
        check("R8 wrap addr", addr_out, a0);
        check("R8 wrap beat", {15'h0, beat}, 17'h0);

        // R5 interleaved sequence from 01: 01,00,11,10
        a0 = 17'h0_ABCD;
        step(1'b0, 1'b0, a0, 1'b1, "R2 load");
        step(1'b1, 1'b0, '0, 1'b1, "R5 interleave");
        check("R5 il beat1", {15'h0, addr_out[1:0]}, 17'h0);
        step(1'b1, 1'b0, '0, 1'b1, "R5 interleave");
        check("R5 il beat2", {15'h0, addr_out[1:0]}, 17'h3);
        step(1'b1, 1'b0, '0, 1'b1, "R5 interleave");
        check("R5 il beat3", {15'h0, addr_out[1:0]}, 17'h2);

        // R7 stall ignores load and advance
        step(1'b0, 1'b1, 17'h1_FFFF, 1'b1, "R7 stall load");
        check("R7 stall keeps", {15'h0, addr_out[1:0]}, 17'h2);
        step(1'b1, 1'b1, 17'h0_0000, 1'b1, "R7 stall adv");
        check("R7 stall beat", {15'h0, beat}, 17'h3);
        step(1'b1, 1'b0, '0, 1'b1, "R8 wrap");
        check("R8 il wrap", addr_out, a0);

        // random mix
        for (int i = 0; i < 3000; i++) begin
            logic r_adv, r_hold, r_il;
            int   pick;
            string req;
            pick   = int'($urandom_range(0, 9));
            r_adv  = (pick >= 3);
            r_hold = ($urandom_range(0, 5) == 0);
            r_il   = (i / 300) % 2 == 1;
            if (r_hold)      req = "R7 stall";
            else if (!r_adv) req = "R2 load";
            else if (r_il)   req = "R5 interleave";
            else             req = "R4 linear";
            step(r_adv, r_hold, ADDR_W'($urandom), r_il, req);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule